// File: doc/BRIEF.md
# Single-Wire Link Resynchronization Sequencer

This block runs on the host side of a single-wire token link to a peripheral that falls asleep on its own. When the host has sent a transmit flag and no reply arrives, the two ends no longer agree on framing. The host then pulses `start_i`, and this sequencer restores order. First it keeps the line quiet long enough for the peripheral to drop into sleep. Next it asks the token PHY for a wake token and waits out the wake low-plus-high delay. Then it asks for a transmit token and waits for the status byte.

A status byte equal to the success code (0x11) ends the recovery with success. A different byte counts the same as silence, and so does a pulse on the external response-timeout input. Either one moves the sequencer to the next, longer quiet wait. There are three attempts in all. The first waits one timeout. The second waits twice the timeout. The third waits a full device watchdog interval, which clears internal faults that nothing outside the device can reset. If the third attempt also fails, the sequencer reports failure. Bit serialization is handled in the PHY, which assembles the least-significant-bit-first wire bits into a parallel byte before they reach this block. An abort input returns the sequencer to rest at any time.

Top module: `resync_ctrl`

## Requirements
- R1: After reset, and whenever it is at rest, all outputs are 0.
- R2: A `start_i` pulse while at rest raises `busy_o` on the next cycle, and the first quiet stretch then lasts exactly T_TIMEOUT cycles.
- R3: Each quiet stretch is followed by exactly one cycle of `tok_wake_o`. After that come exactly T_WLO+T_WHI cycles with no token request, and then exactly one cycle of `tok_xmit_o`.
- R4: While the sequencer waits for a response, an `rx_valid_i` pulse with `rx_byte_i` = 0x11 produces a one-cycle `done_o` together with `success_o` on the next cycle, and then returns to rest.
- R5: While the sequencer waits for a response, a byte other than 0x11, or a `rsp_timeout_i` pulse, starts the next attempt. The second attempt's quiet stretch lasts 2*T_TIMEOUT cycles.
- R6: The third attempt's quiet stretch lasts T_WATCHDOG cycles.
- R7: A failed third attempt produces a one-cycle `done_o` together with `fail_o`. No further token is requested.
- R8: `abort_i` returns the sequencer to rest on the next cycle from any state. It takes priority over `start_i` and over a received byte in the same cycle.
- R9: `rx_valid_i` and `rsp_timeout_i` outside the response wait, and `start_i` while busy, have no effect on the outputs or on the timing.
- R10: No token is requested during a quiet stretch. A wake request always directly follows the last quiet cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a recovery |
| abort_i | input | 1 | Return to rest at once |
| rsp_timeout_i | input | 1 | Host-side reply timeout expired |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received status byte |
| tok_wake_o | output | 1 | Request a wake token from the PHY |
| tok_xmit_o | output | 1 | Request a transmit token from the PHY |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | Recovery finished (one cycle) |
| success_o | output | 1 | Finished with success code |
| fail_o | output | 1 | Finished after all attempts failed |

## Verification
The bench tries several recoveries. One succeeds on the first attempt. One fails with a wrong byte, then a timeout, then another wrong byte. One succeeds on the second attempt. Together these separate the three quiet-stretch lengths and show that a wrong byte counts the same as silence. Stray strobes and repeated starts are then sent during the quiet and delay stretches, which shows whether they disturb the timing. Aborts are sent in the quiet, delay and response phases, including an abort together with a valid success byte, which checks the priority rule.

// File: rtl/resync_pkg.sv
package resync_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUIET,
        ST_WAKE,
        ST_DLY,
        ST_XMIT,
        ST_RESP,
        ST_DONE
    } state_e;

    localparam int unsigned RUNG_W = 2;

    typedef struct packed {
        state_e             st;
        logic [RUNG_W-1:0]  rung;
        logic               ok;
    } ctl_t;

endpackage

// File: rtl/resync_timer.sv
module resync_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R2: once run down, the count stays at zero until reloaded
    a_r2_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/resync_wait_sel.sv
module resync_wait_sel #(
    parameter int T_TIMEOUT  = 16,
    parameter int T_WATCHDOG = 80,
    parameter int CW         = 8
) (
    input  logic [1:0]    rung_i,
    output logic [CW-1:0] quiet_len_o
);
    localparam logic [CW-1:0] LEN_SINGLE = CW'(T_TIMEOUT - 1);
    localparam logic [CW-1:0] LEN_DOUBLE = CW'(2 * T_TIMEOUT - 1);
    localparam logic [CW-1:0] LEN_WDOG   = CW'(T_WATCHDOG - 1);

    always_comb begin
        case (rung_i)
            2'd0:    quiet_len_o = LEN_SINGLE;
            2'd1:    quiet_len_o = LEN_DOUBLE;
            default: quiet_len_o = LEN_WDOG;
        endcase
    end

endmodule

// File: rtl/resync_status_chk.sv
module resync_status_chk #(
    parameter logic [7:0] OK_CODE = 8'h11
) (
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    output logic       hit_o,
    output logic       miss_o
);
    assign hit_o  = rx_valid_i && (rx_byte_i == OK_CODE);
    assign miss_o = rx_valid_i && (rx_byte_i != OK_CODE);
endmodule

// File: rtl/resync_ctrl.sv
module resync_ctrl
    import resync_pkg::*;
#(
    parameter int         T_TIMEOUT  = 16,
    parameter int         T_WLO      = 3,
    parameter int         T_WHI      = 5,
    parameter int         T_WATCHDOG = 80,
    parameter logic [7:0] OK_CODE    = 8'h11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       abort_i,
    input  logic       rsp_timeout_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    output logic       tok_wake_o,
    output logic       tok_xmit_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       success_o,
    output logic       fail_o
);
    localparam int WAKE_DLY = T_WLO + T_WHI;
    localparam int MAX_A    = (2 * T_TIMEOUT > T_WATCHDOG) ? 2 * T_TIMEOUT : T_WATCHDOG;
    localparam int MAX_WAIT = (MAX_A > WAKE_DLY) ? MAX_A : WAKE_DLY;
    localparam int CW       = $clog2(MAX_WAIT + 1);
    localparam logic [CW-1:0]     DLY_LEN   = CW'(WAKE_DLY - 1);
    localparam logic [RUNG_W-1:0] LAST_RUNG = RUNG_W'(2);

    ctl_t              ctl_d, ctl_q;
    logic              tmr_load, tmr_zero;
    logic [CW-1:0]     tmr_val, quiet_len;
    logic [RUNG_W-1:0] sel_rung;
    logic              byte_hit, byte_miss;

    // rung whose quiet length will be loaded next
    assign sel_rung = (ctl_q.st == ST_RESP) ? ctl_q.rung + 1'b1 : '0;

    resync_wait_sel #(
        .T_TIMEOUT (T_TIMEOUT),
        .T_WATCHDOG(T_WATCHDOG),
        .CW        (CW)
    ) u_wait_sel (
        .rung_i     (sel_rung),
        .quiet_len_o(quiet_len)
    );

    resync_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .zero_o    (tmr_zero)
    );

    resync_status_chk #(.OK_CODE(OK_CODE)) u_chk (
        .rx_valid_i(rx_valid_i),
        .rx_byte_i (rx_byte_i),
        .hit_o     (byte_hit),
        .miss_o    (byte_miss)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = quiet_len;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_QUIET;
                    ctl_d.rung = '0;
                    ctl_d.ok   = 1'b0;
                    tmr_load   = 1'b1;
                end
            end
            ST_QUIET: begin
                if (tmr_zero) ctl_d.st = ST_WAKE;
            end
            ST_WAKE: begin
                ctl_d.st = ST_DLY;
                tmr_load = 1'b1;
                tmr_val  = DLY_LEN;
            end
            ST_DLY: begin
                if (tmr_zero) ctl_d.st = ST_XMIT;
            end
            ST_XMIT: begin
                ctl_d.st = ST_RESP;
            end
            ST_RESP: begin
                if (byte_hit) begin
                    ctl_d.st = ST_DONE;
                    ctl_d.ok = 1'b1;
                end else if (byte_miss || rsp_timeout_i) begin
                    if (ctl_q.rung == LAST_RUNG) begin
                        ctl_d.st = ST_DONE;
                        ctl_d.ok = 1'b0;
                    end else begin
                        ctl_d.st   = ST_QUIET;
                        ctl_d.rung = ctl_q.rung + 1'b1;
                        tmr_load   = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (abort_i) ctl_d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.rung <= '0;
            ctl_q.ok   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tok_wake_o = (ctl_q.st == ST_WAKE);
    assign tok_xmit_o = (ctl_q.st == ST_XMIT);
    assign busy_o     = (ctl_q.st != ST_IDLE);
    assign done_o     = (ctl_q.st == ST_DONE);
    assign success_o  = done_o && ctl_q.ok;
    assign fail_o     = done_o && !ctl_q.ok;

    a_r3_xmit_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_DLY && tmr_zero && !abort_i) |=> tok_xmit_o);

    a_r4_success_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
        success_o |-> $past(rx_valid_i && rx_byte_i == OK_CODE && !abort_i));

    a_r7_fail_on_last_rung: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> $past(ctl_q.rung == LAST_RUNG && !abort_i));

    a_r8_abort_rest: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !tok_wake_o && !tok_xmit_o && !done_o));

    a_r10_wake_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tok_wake_o |-> $past(ctl_q.st == ST_QUIET && tmr_zero));

    a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tok_wake_o, tok_xmit_o, done_o}));

endmodule

// File: tb/resync_ctrl_bench.sv
module resync_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TT  = 16;
    localparam int TLO = 3;
    localparam int THI = 5;
    localparam int TWD = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, abort = 1'b0, rsp_to = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       wake, xmit, busy, done, succ, fail;

    int n_cmp = 0, n_bad = 0;
    bit reported = 0;
    string cur = "R1";

    // behavioural reference
    int m_ph = 0, m_left = 0, m_rung = 0;
    bit m_ok = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resync_ctrl #(
        .T_TIMEOUT(TT), .T_WLO(TLO), .T_WHI(THI), .T_WATCHDOG(TWD), .OK_CODE(8'h11)
    ) u_resync_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .rsp_timeout_i(rsp_to), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .tok_wake_o(wake), .tok_xmit_o(xmit), .busy_o(busy), .done_o(done),
        .success_o(succ), .fail_o(fail)
    );

    function automatic int quiet_of(int r);
        if (r == 0) return TT;
        if (r == 1) return 2 * TT;
        return TWD;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_rung = 0; m_ok = 0;
        end else if (abort) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: if (start) begin m_ph = 1; m_rung = 0; m_ok = 0; m_left = quiet_of(0); end
                1: begin m_left--; if (m_left == 0) m_ph = 2; end
                2: begin m_ph = 3; m_left = TLO + THI; end
                3: begin m_left--; if (m_left == 0) m_ph = 4; end
                4: m_ph = 5;
                5: begin
                    if (rx_valid && rx_byte == 8'h11) begin m_ph = 6; m_ok = 1; end
                    else if (rx_valid || rsp_to) begin
                        if (m_rung == 2) begin m_ph = 6; m_ok = 0; end
                        else begin m_rung++; m_ph = 1; m_left = quiet_of(m_rung); end
                    end
                end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(string nm, string rq, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s actual=%0b expected=%0b at %0t", rq, cur, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!reported) begin
            chk("tok_wake",  "R3 R10", wake, m_ph == 2);
            chk("tok_xmit",  "R3",     xmit, m_ph == 4);
            chk("busy",      "R2",     busy, m_ph != 0);
            chk("done",      "R4 R7",  done, m_ph == 6);
            chk("success",   "R4",     succ, m_ph == 6 && m_ok);
            chk("fail",      "R7",     fail, m_ph == 6 && !m_ok);
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ph(int p);
        while (m_ph != p) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        tick();
        rx_valid = 1'b0; rx_byte = 8'h00;
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    initial begin
        // R1: reset state and rest
        tick(4);
        rst_n = 1'b1;
        tick(3);

        // R2 R3 R4: success on first attempt
        cur = "R2 R3 R4";
        pulse_start();
        wait_ph(5); tick(2);
        send_byte(8'h11);
        wait_ph(0); tick(2);

        // R5 R6 R7: wrong byte, timeout, wrong byte -> fail
        cur = "R5 R6 R7";
        pulse_start();
        wait_ph(5); send_byte(8'h10);
        wait_ph(5); rsp_to = 1'b1; tick(); rsp_to = 1'b0;
        wait_ph(5); send_byte(8'h91);
        wait_ph(0); tick(3);

        // R5 R4: success on second attempt
        cur = "R5 R4";
        pulse_start();
        wait_ph(5); send_byte(8'h22);
        wait_ph(5); send_byte(8'h11);
        wait_ph(0); tick(2);

        // R9: stray strobes and repeated start are ignored
        cur = "R9";
        send_byte(8'h11);
        rsp_to = 1'b1; tick(); rsp_to = 1'b0;
        pulse_start();
        tick(5);
        send_byte(8'h11);
        pulse_start();
        rsp_to = 1'b1; tick(); rsp_to = 1'b0;
        wait_ph(3); tick();
        send_byte(8'h11);
        rsp_to = 1'b1; tick(); rsp_to = 1'b0;
        wait_ph(5); rsp_to = 1'b1; tick(); rsp_to = 1'b0;
        wait_ph(5); send_byte(8'h11);
        wait_ph(0); tick(2);

        // R8: abort in each phase and with a success byte
        cur = "R8";
        pulse_start(); tick(7);
        abort = 1'b1; tick(); abort = 1'b0; tick(3);
        start = 1'b1; abort = 1'b1; tick(); start = 1'b0; abort = 1'b0; tick(2);
        pulse_start(); wait_ph(3); tick();
        abort = 1'b1; tick(); abort = 1'b0; tick(2);
        pulse_start(); wait_ph(5);
        abort = 1'b1; rx_valid = 1'b1; rx_byte = 8'h11; tick();
        abort = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
        tick(4);

        report();
    end

endmodule